// File: doc/BRIEF.md
# Integer ALU with Condition-Code Register

This block is a 32-bit integer arithmetic and logic unit for a processor execution stage. Each cycle in which the valid strobe is high, it takes two operands and a three-bit operation select. It computes one of eight operations: add, subtract, AND, OR, XOR, bitwise complement, increment or decrement. It registers the result. In the same edge it updates a status word that holds six condition codes: sign, zero, signed overflow, nibble carry, carry/borrow and low-byte even parity.

The status word can also be written directly from a load port, for example when a saved context is restored. A direct write wins over an ALU update that falls in the same cycle. Bits of the status word that hold no condition code always read zero.

Top module: `flag_alu`

## Requirements
- R1: The operation select is encoded as 0=ADD (A+B), 1=SUB (A-B), 2=AND, 3=OR, 4=XOR, 5=NOT (~A), 6=INC (A+1), 7=DEC (A-1). When `inValid` is high at a rising edge, the result appears on `result` and `outValid` is high after that same edge; `outValid` is low after an edge where `inValid` was low.
- R2: The sign flag (bit 7) equals bit 31 of the new result.
- R3: The zero flag (bit 6) is 1 exactly when all 32 bits of the new result are zero.
- R4: The overflow flag (bit 11) is 1 when ADD/INC or SUB/DEC gives a result whose sign cannot be correct for two's-complement operands.
- R5: The carry flag (bit 0) is the carry out of bit 31 for ADD/INC. For SUB/DEC it is the borrow, that is, 1 when the unsigned A is smaller than the unsigned subtrahend.
- R6: The nibble flag (bit 4) is the carry out of bit 3 for ADD/INC. For SUB/DEC it is 1 when A[3:0] is smaller than the subtrahend's low four bits.
- R7: The parity flag (bit 2) is 1 when result bits 7:0 contain an even number of ones.
- R8: AND, OR, XOR and NOT clear the overflow, carry and nibble flags.
- R9: All status bits other than 0, 2, 4, 6, 7 and 11 always read 0.
- R10: When `flagLoad` is high at an edge, the status word takes `flagLoadData` with the unused bits masked to 0. This takes priority over an ALU update in the same edge, but the result of that operation is still registered.
- R11: When neither `inValid` nor `flagLoad` is high, `result` and `flags` hold their values.
- R12: After reset, `result`, `flags` and `outValid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation strobe |
| opSel | input | 3 | Operation select (see R1) |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand (used by ADD, SUB, AND, OR, XOR) |
| flagLoad | input | 1 | Direct write of the status word |
| flagLoadData | input | 16 | Value for the direct write |
| result | output | 32 | Registered result |
| flags | output | 16 | Registered status word |
| outValid | output | 1 | High for one cycle after an accepted operation |

## Verification
The result, the status word and `outValid` all come from one register stage. They are therefore due exactly one rising edge after the stimulus, and a direct status load shows up after that same single edge. The driver applies inputs on the falling edge and pushes the expected item into a queue. The monitor samples on the next falling edge, after the capturing rising edge, pops one item for each cycle in which `outValid` is high, and compares both words. Checks for loads and idle cycles are also sampled one falling edge after the edge that should, or should not, have changed the outputs.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_NOT = 3'd5,
    OP_INC = 3'd6,
    OP_DEC = 3'd7
  } op_e;

  localparam int FLAG_W = 16;
  localparam int BIT_C = 0;
  localparam int BIT_P = 2;
  localparam int BIT_A = 4;
  localparam int BIT_Z = 6;
  localparam int BIT_N = 7;
  localparam int BIT_V = 11;
  localparam logic [FLAG_W-1:0] FLAG_MASK =
    (FLAG_W'(1) << BIT_C) | (FLAG_W'(1) << BIT_P) | (FLAG_W'(1) << BIT_A) |
    (FLAG_W'(1) << BIT_Z) | (FLAG_W'(1) << BIT_N) | (FLAG_W'(1) << BIT_V);

  // strobes from control to datapath
  typedef struct packed {
    logic       aluWrite;
    logic       flagWrite;
    logic       doSub;
    logic       useOne;
    logic       doLogic;
    logic [1:0] logicSel;  // 0 and, 1 or, 2 xor, 3 not
  } ctrl_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import flag_alu_pkg::*;
(
  input  logic       inValid,
  input  logic [2:0] opSel,
  input  logic       flagLoad,
  output ctrl_t      ctl
);
  always_comb begin
    ctl           = '0;
    ctl.aluWrite  = inValid;
    ctl.flagWrite = flagLoad;
    unique case (op_e'(opSel))
      OP_ADD: ;
      OP_SUB: ctl.doSub = 1'b1;
      OP_INC: ctl.useOne = 1'b1;
      OP_DEC: begin ctl.doSub = 1'b1; ctl.useOne = 1'b1; end
      OP_AND: begin ctl.doLogic = 1'b1; ctl.logicSel = 2'd0; end
      OP_OR:  begin ctl.doLogic = 1'b1; ctl.logicSel = 2'd1; end
      OP_XOR: begin ctl.doLogic = 1'b1; ctl.logicSel = 2'd2; end
      OP_NOT: begin ctl.doLogic = 1'b1; ctl.logicSel = 2'd3; end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_dp.sv
module alu_dp
  import flag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctl,
  input  logic [W-1:0]      opA,
  input  logic [W-1:0]      opB,
  input  logic [FLAG_W-1:0] loadData,
  output logic [W-1:0]      result,
  output logic [FLAG_W-1:0] flags,
  output logic              outValid
);
  localparam int MSB = W - 1;

  logic [W-1:0]      bEff;
  logic [W:0]        wide;
  logic [4:0]        nib;
  logic [W-1:0]      logicRes;
  logic [W-1:0]      resNext;
  logic              ovf;
  logic [FLAG_W-1:0] flagsNext;

  always_comb begin
    bEff = ctl.useOne ? W'(1) : opB;
    if (ctl.doSub) begin
      wide = {1'b0, opA} - {1'b0, bEff};
      nib  = {1'b0, opA[3:0]} - {1'b0, bEff[3:0]};
      ovf  = (opA[MSB] != bEff[MSB]) && (wide[MSB] != opA[MSB]);
    end else begin
      wide = {1'b0, opA} + {1'b0, bEff};
      nib  = {1'b0, opA[3:0]} + {1'b0, bEff[3:0]};
      ovf  = (opA[MSB] == bEff[MSB]) && (wide[MSB] != opA[MSB]);
    end
    case (ctl.logicSel)
      2'd0:    logicRes = opA & opB;
      2'd1:    logicRes = opA | opB;
      2'd2:    logicRes = opA ^ opB;
      default: logicRes = ~opA;
    endcase
    resNext = ctl.doLogic ? logicRes : wide[MSB:0];

    flagsNext        = '0;
    flagsNext[BIT_C] = ~ctl.doLogic & wide[W];
    flagsNext[BIT_A] = ~ctl.doLogic & nib[4];
    flagsNext[BIT_V] = ~ctl.doLogic & ovf;
    flagsNext[BIT_N] = resNext[MSB];
    flagsNext[BIT_Z] = (resNext == '0);
    flagsNext[BIT_P] = ~^resNext[7:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result   <= '0;
      flags    <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= ctl.aluWrite;
      if (ctl.aluWrite) result <= resNext;
      if (ctl.flagWrite)     flags <= loadData & FLAG_MASK;
      else if (ctl.aluWrite) flags <= flagsNext;
    end
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [2:0]        opSel,
  input  logic [W-1:0]      opA,
  input  logic [W-1:0]      opB,
  input  logic              flagLoad,
  input  logic [FLAG_W-1:0] flagLoadData,
  output logic [W-1:0]      result,
  output logic [FLAG_W-1:0] flags,
  output logic              outValid
);
  ctrl_t ctl;

  alu_ctrl u_ctrl (
    .inValid (inValid),
    .opSel   (opSel),
    .flagLoad(flagLoad),
    .ctl     (ctl)
  );

  alu_dp #(.W(W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .opA     (opA),
    .opB     (opB),
    .loadData(flagLoadData),
    .result  (result),
    .flags   (flags),
    .outValid(outValid)
  );
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk
  import flag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [2:0]        opSel,
  input logic [W-1:0]      opA,
  input logic [W-1:0]      opB,
  input logic              flagLoad,
  input logic [FLAG_W-1:0] flagLoadData,
  input logic [W-1:0]      result,
  input logic [FLAG_W-1:0] flags,
  input logic              outValid
);
  // R1
  out_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R1
  add_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 3'd0) |=> result == $past(opA) + $past(opB));

  // R3
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !flagLoad) |=> flags[BIT_Z] == (result == '0));

  // R8
  logic_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !flagLoad && opSel >= 3'd2 && opSel <= 3'd5)
      |=> !flags[BIT_C] && !flags[BIT_V] && !flags[BIT_A]);

  // R10
  load_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagLoad |=> flags == ($past(flagLoadData) & FLAG_MASK));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && !flagLoad) |=> $stable(flags) && $stable(result) && !outValid);
endmodule

bind flag_alu flag_alu_chk #(.W(W)) u_chk (.*);

// File: tb/flag_alu_tb.sv
module flag_alu_tb;
  localparam int W = 32;
  localparam logic [15:0] MASK = 16'h08D5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [2:0] opSel = '0;
  logic [W-1:0] opA = '0, opB = '0;
  logic flagLoad = 1'b0;
  logic [15:0] flagLoadData = '0;
  logic [W-1:0] result;
  logic [15:0] flags;
  logic outValid;

  always #4 clk = ~clk;  // 125 MHz

  flag_alu #(.W(W)) u_dut (.*);

  typedef struct {
    logic [W-1:0] r;
    logic [15:0]  f;
    string        tag;
  } exp_t;
  exp_t q[$];

  int checks = 0;
  int fails = 0;
  logic [W-1:0] lastR = '0;
  logic [15:0] lastF = '0;

  task automatic check(input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [2:0] op, input logic [W-1:0] a,
                                input logic [W-1:0] b, output logic [W-1:0] r,
                                output logic [15:0] f);
    logic [W:0] w;
    logic [4:0] n;
    logic [W-1:0] s;
    logic sub, lg;
    lg  = (op >= 3'd2 && op <= 3'd5);
    sub = (op == 3'd1 || op == 3'd7);
    s   = (op == 3'd6 || op == 3'd7) ? W'(1) : b;
    w = sub ? ({1'b0, a} - {1'b0, s}) : ({1'b0, a} + {1'b0, s});
    n = sub ? ({1'b0, a[3:0]} - {1'b0, s[3:0]}) : ({1'b0, a[3:0]} + {1'b0, s[3:0]});
    case (op)
      3'd2: r = a & b;
      3'd3: r = a | b;
      3'd4: r = a ^ b;
      3'd5: r = ~a;
      default: r = w[W-1:0];
    endcase
    f = '0;
    f[7] = r[W-1];
    f[6] = (r == '0);
    f[2] = ~^r[7:0];
    if (!lg) begin
      f[0] = w[W];
      f[4] = n[4];
      if (sub) f[11] = (a[W-1] != s[W-1]) && (r[W-1] != a[W-1]);
      else     f[11] = (a[W-1] == s[W-1]) && (r[W-1] != a[W-1]);
    end
  endfunction

  // driver: one operation per cycle, optionally with a flag load
  task automatic drive(input logic [2:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b, input string tag,
                       input logic ld = 1'b0, input logic [15:0] ldv = '0);
    exp_t e;
    @(negedge clk);
    inValid = 1'b1; opSel = op; opA = a; opB = b;
    flagLoad = ld; flagLoadData = ldv;
    model(op, a, b, e.r, e.f);
    if (ld) e.f = ldv & MASK;
    e.tag = tag;
    q.push_back(e);
    lastR = e.r; lastF = e.f;
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0; flagLoad = 1'b0;
  endtask

  // monitor: compares one item per cycle with outValid high
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (q.size() == 0) begin
        check("R1 unexpected outValid", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check({e.tag, " result"}, result, e.r);
        check({e.tag, " flags"}, W'(flags), W'(e.f));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check("watchdog", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 result", result, '0);
    check("R12 flags", W'(flags), '0);
    check("R12 outValid", W'(outValid), '0);
    rstN = 1'b1;

    drive(3'd0, 32'h7FFF_FFFF, 32'h1, "R4 R6 R2 add overflow");
    drive(3'd0, 32'hFFFF_FFFF, 32'h1, "R5 R3 R7 add carry zero");
    drive(3'd1, 32'h0, 32'h1, "R5 R6 sub borrow");
    drive(3'd1, 32'h8000_0000, 32'h1, "R4 sub overflow");
    drive(3'd1, 32'h1234_5678, 32'h1234_5678, "R3 sub equal");
    drive(3'd2, 32'hF0F0_FFFF, 32'h0F0F_0F0F, "R8 and");
    drive(3'd3, 32'h8000_0000, 32'h0000_0003, "R8 R7 or");
    drive(3'd4, 32'hAAAA_AAAA, 32'hAAAA_AAAA, "R8 R3 xor");
    drive(3'd5, 32'h0000_0001, 32'h0, "R8 R2 not");
    drive(3'd6, 32'h7FFF_FFFF, 32'h0, "R1 R4 inc");
    drive(3'd7, 32'h0000_0010, 32'h0, "R1 R6 dec");
    drive(3'd0, 32'h0000_000F, 32'h0000_0001, "R6 add nibble");
    for (int i = 0; i < 6; i++)
      drive(3'(i), 32'h1357_9BDF + 32'(i) * 32'h0111_0000, 32'hFEDC_BA98, "R1 mixed");
    drive(3'd0, 32'hFFFF_FFFF, 32'h1, "R10 load priority", 1'b1, 16'hFFFF);
    idle();
    // R11 idle hold
    repeat (2) @(negedge clk);
    check("R11 result hold", result, lastR);
    check("R11 flags hold", W'(flags), W'(lastF));
    check("R1 outValid low", W'(outValid), '0);
    // R10 plain load, R9 mask
    flagLoad = 1'b1; flagLoadData = 16'hF72A;
    @(negedge clk);
    flagLoad = 1'b0;
    check("R9 masked load", W'(flags), '0);
    check("R10 result untouched", result, lastR);
    flagLoad = 1'b1; flagLoadData = 16'h0ADF;
    @(negedge clk);
    flagLoad = 1'b0;
    check("R10 load value", W'(flags), W'(16'h0ADF & MASK));
    repeat (3) @(negedge clk);
    check("R1 queue drained", W'(q.size()), '0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule